// File: doc/BRIEF.md
# Packed Float/Word Conversion Unit

A two-lane datapath stage for a packed 64-bit register file. Each operand carries two 32-bit lanes, and every operation works on both lanes at once under the same rules. One operation turns single-precision lanes into saturated signed 16-bit integers that are sign-extended to a full lane. A second turns signed 16-bit words into exact single-precision values. A third exchanges the two lanes. The fourth select code forwards the operand unchanged.

Operands arrive on a valid/ready stream, and results leave on another. The stage is a single output register. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high, and its result is presented on the next cycle. While the consumer holds `out_ready` low and a result is pending, `in_ready` is low and the pending result stays frozen. With `out_ready` held high, `out_valid` follows `in_valid` one clock later, and the stage can take a new operand every cycle.

Top module: `pkcvt_unit`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears `out_valid` and drives `out_data` to zero.
- R2: `in_ready` equals `!out_valid || out_ready`. An accepted operand produces `out_valid` high on the following cycle. A result that is not taken keeps `out_valid` and `out_data` unchanged.
- R3: Select `00` converts each lane as a single-precision float to an integer, rounding toward zero. An in-range result is a 16-bit two's-complement value with bits [31:16] of the lane copying bit 15.
- R4: Under select `00`, a lane value of 2^15 or more, including +infinity, yields 0x0000_7FFF.
- R5: Under select `00`, a lane value of -2^15 or less, including -infinity, yields 0xFFFF_8000.
- R6: Under select `00`, a lane that is zero of either sign, denormal, or smaller than 1 in magnitude yields zero.
- R7: Select `01` converts operand bits [15:0] into result [31:0] and bits [47:32] into result [63:32], each as a signed word, exactly and to single precision. Operand bits [31:16] and [63:48] have no effect. A zero word gives +0.0 (all bits zero).
- R8: Select `10` puts operand [31:0] in result [63:32] and operand [63:32] in result [31:0].
- R9: Select `11` returns the operand unchanged.
- R10: The lanes are independent: each lane's result depends only on the bits of its own source lane, or of the opposite lane under select `10`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Stage can take an operand |
| in_op | input | 2 | Operation select |
| in_data | input | 64 | Packed operand, two 32-bit lanes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Packed result |

## Verification
The stage holds one result, so a fault in its state or handshake shows at the ports within a cycle or two. A dropped or doubled operand appears as `out_valid` disagreeing with the model on the next clock. A result that changes during a stall shows as a data miscompare in the cycle after `out_ready` falls. Conversion faults have no later effect, because no state crosses operations. They show only in the result of the operand that caused them, so the exponent boundaries at ±2^15, values just below one, infinities, denormals and the most negative word are driven directly rather than left to random operands.

// File: rtl/pkcvt_pkg.sv
package pkcvt_pkg;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int SP_BIAS  = 127;

  typedef enum logic [1:0] {
    OP_F2W  = 2'b00,
    OP_W2F  = 2'b01,
    OP_SWAP = 2'b10,
    OP_PASS = 2'b11
  } pk_op_e;
endpackage

// File: rtl/pkcvt_f2w.sv
module pkcvt_f2w
  import pkcvt_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int INT_W  = 16
) (
  input  logic [LANE_W-1:0] f,
  output logic [LANE_W-1:0] q
);
  localparam int EXT_W = LANE_W - INT_W;
  localparam logic [SP_EXP_W-1:0] EXP_ONE = SP_EXP_W'(SP_BIAS);
  localparam logic [SP_EXP_W-1:0] EXP_SAT = SP_EXP_W'(SP_BIAS + INT_W - 1);
  localparam logic [SP_EXP_W-1:0] MAN_SH  = SP_EXP_W'(SP_MAN_W);

  logic                  sgn;
  logic [SP_EXP_W-1:0]   ex;
  logic [SP_MAN_W:0]     sig;
  logic [SP_EXP_W-1:0]   sh;
  logic [INT_W-1:0]      mag;
  logic [INT_W-1:0]      val;
  logic                  sat;

  assign sgn = f[LANE_W-1];
  assign ex  = f[LANE_W-2 -: SP_EXP_W];
  assign sig = {1'b1, f[SP_MAN_W-1:0]};
  assign sh  = MAN_SH - (ex - EXP_ONE);

  always_comb begin
    sat = 1'b0;
    mag = '0;
    if (ex >= EXP_SAT) begin
      // covers infinity and NaN codes as well
      sat = 1'b1;
    end else if (ex >= EXP_ONE) begin
      mag = INT_W'(sig >> sh);
    end
  end

  assign val = sgn ? (~mag + 1'b1) : mag;

  always_comb begin
    if (sat) q = sgn ? {{(EXT_W+1){1'b1}}, {(INT_W-1){1'b0}}}
                     : {{(EXT_W+1){1'b0}}, {(INT_W-1){1'b1}}};
    else     q = {{EXT_W{val[INT_W-1]}}, val};
  end
endmodule

// File: rtl/pkcvt_w2f.sv
module pkcvt_w2f
  import pkcvt_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int INT_W  = 16
) (
  input  logic [INT_W-1:0]  w,
  output logic [LANE_W-1:0] q
);
  localparam int LW   = $clog2(INT_W);
  localparam int PADW = SP_MAN_W - (INT_W - 1);
  localparam logic [LW-1:0] TOPBIT = LW'(INT_W - 1);

  logic                 sgn;
  logic [INT_W-1:0]     mag;
  logic [LW-1:0]        lead;
  logic [INT_W-2:0]     norm;
  logic [SP_EXP_W-1:0]  ex;

  assign sgn = w[INT_W-1];
  assign mag = sgn ? (~w + 1'b1) : w;

  always_comb begin
    lead = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) lead = LW'(i);
    end
  end

  assign norm = (INT_W-1)'(mag << (TOPBIT - lead));
  assign ex   = SP_EXP_W'(SP_BIAS) + SP_EXP_W'(lead);

  always_comb begin
    if (mag == '0) q = '0;
    else           q = {sgn, ex, norm, {PADW{1'b0}}};
  end
endmodule

// File: rtl/pkcvt_unit.sv
module pkcvt_unit
  import pkcvt_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 32,
  parameter int INT_W  = 16,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  pk_op_e            op_sel;
  logic [DATA_W-1:0] res_f2w, res_w2f, res_swap, res_next;
  logic              take;

  assign op_sel = pk_op_e'(in_op);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pkcvt_f2w #(.LANE_W(LANE_W), .INT_W(INT_W)) u_f2w (
      .f (in_data[l*LANE_W +: LANE_W]),
      .q (res_f2w[l*LANE_W +: LANE_W])
    );
    pkcvt_w2f #(.LANE_W(LANE_W), .INT_W(INT_W)) u_w2f (
      .w (in_data[l*LANE_W +: INT_W]),
      .q (res_w2f[l*LANE_W +: LANE_W])
    );
    assign res_swap[l*LANE_W +: LANE_W] = in_data[(LANES-1-l)*LANE_W +: LANE_W];
  end

  always_comb begin
    unique case (op_sel)
      OP_F2W:  res_next = res_f2w;
      OP_W2F:  res_next = res_w2f;
      OP_SWAP: res_next = res_swap;
      default: res_next = in_data;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     out_data  <= res_next;
    end
  end

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  // R2
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R2
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R3
  p_f2w_sext_r3: assert property (@(posedge clk) disable iff (rst)
    (take && in_op == 2'b00) |=>
      (out_data[LANE_W-1:INT_W] == {(LANE_W-INT_W){out_data[INT_W-1]}}));

  // R7
  p_w2f_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (take && in_op == 2'b01 && in_data[INT_W-1:0] == '0) |=>
      (out_data[LANE_W-1:0] == '0));

  // R8
  p_swap_r8: assert property (@(posedge clk) disable iff (rst)
    (take && in_op == 2'b10) |=>
      (out_data[LANE_W-1:0] == $past(in_data[DATA_W-1 -: LANE_W])));

  // R9
  p_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (take && in_op == 2'b11) |=> (out_data == $past(in_data)));
endmodule

// File: tb/pkcvt_unit_bench.sv
`timescale 1ns/1ps
module pkcvt_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_op;
  logic [63:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_data;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic        m_valid = 1'b0;
  logic [63:0] m_data  = '0;
  string       m_tag   = "R1";

  always #4 clk = ~clk;

  pkcvt_unit u_pkcvt_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] ref_f2w(input logic [31:0] f);
    real v;
    int  i;
    logic [7:0] e;
    e = f[30:23];
    if (e == 8'd0) return 32'd0;
    if (e == 8'hFF) v = f[31] ? -1.0e12 : 1.0e12;
    else v = $bitstoreal({f[31], 11'(e) + 11'd896, f[22:0], 29'd0});
    if (v >= 32768.0)  return 32'h0000_7FFF;
    if (v <= -32768.0) return 32'hFFFF_8000;
    i = $rtoi(v);
    return 32'(i);
  endfunction

  function automatic logic [31:0] ref_w2f(input logic [15:0] w);
    int i;
    logic [63:0] b;
    logic [10:0] de;
    i = int'($signed(w));
    if (i == 0) return 32'd0;
    b  = $realtobits(real'(i));
    de = b[62:52];
    return {b[63], 8'(de - 11'd896), b[51:29]};
  endfunction

  function automatic logic [63:0] ref_op(input logic [1:0] op, input logic [63:0] d);
    case (op)
      2'b00:   return {ref_f2w(d[63:32]), ref_f2w(d[31:0])};
      2'b01:   return {ref_w2f(d[47:32]), ref_w2f(d[15:0])};
      2'b10:   return {d[31:0], d[63:32]};
      default: return d;
    endcase
  endfunction

  task automatic step(input logic v, input logic [1:0] op, input logic [63:0] d,
                      input logic rdy, input string tag);
    @(negedge clk);
    vectors++;
    if (out_valid !== m_valid) begin
      errors++;
      $display("FAIL R2 (%s): out_valid=%b expected %b", m_tag, out_valid, m_valid);
    end else if (m_valid && out_data !== m_data) begin
      errors++;
      $display("FAIL %s: out_data=%h expected %h", m_tag, out_data, m_data);
    end
    in_valid  = v;
    in_op     = op;
    in_data   = d;
    out_ready = rdy;
    #1;
    if (in_ready !== (!m_valid || rdy)) begin
      errors++;
      $display("FAIL R2: in_ready=%b expected %b", in_ready, (!m_valid || rdy));
    end
    if (!m_valid || rdy) begin
      if (v) begin
        m_data = ref_op(op, d);
        m_tag  = tag;
      end
      m_valid = v;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_op = 2'b00; in_data = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || out_data !== 64'd0) begin
      errors++;
      $display("FAIL R1: valid=%b data=%h expected 0 0", out_valid, out_data);
    end
    rst = 1'b0;
    step(0, 2'b00, 64'd0, 1, "R1");

    // R3: truncation, sign extension
    step(1, 2'b00, {32'h3FC0_0000, 32'hBFC0_0000}, 1, "R3");
    step(1, 2'b00, {32'h46FF_FE00, 32'hC6FF_FE00}, 1, "R3");
    step(1, 2'b00, {32'hC2F6_E666, 32'h4479_FFFF}, 1, "R3");
    // R4 / R5: saturation and infinities
    step(1, 2'b00, {32'h4700_0000, 32'h7F80_0000}, 1, "R4");
    step(1, 2'b00, {32'h4F00_0000, 32'h4700_0080}, 1, "R4");
    step(1, 2'b00, {32'hC700_0000, 32'hFF80_0000}, 1, "R5");
    step(1, 2'b00, {32'hC700_0080, 32'hCF00_0000}, 1, "R5");
    // R6: zero, denormal, below one
    step(1, 2'b00, {32'h0000_0001, 32'h8000_0000}, 1, "R6");
    step(1, 2'b00, {32'h3F7F_FFFF, 32'hBF7F_FFFF}, 1, "R6");
    // R10: one lane saturating while the other is tiny
    step(1, 2'b00, {32'h7F80_0000, 32'h3F00_0000}, 1, "R10");
    // R7: words, upper words ignored
    step(1, 2'b01, 64'hDEAD_0001_BEEF_FFFF, 1, "R7");
    step(1, 2'b01, 64'h1234_8000_5678_7FFF, 1, "R7");
    step(1, 2'b01, 64'hFFFF_0000_FFFF_0000, 1, "R7");
    // R8, R9
    step(1, 2'b10, 64'h0123_4567_89AB_CDEF, 1, "R8");
    step(1, 2'b11, 64'hFEDC_BA98_7654_3210, 1, "R9");
    // R2: stall holds result, then drains
    step(1, 2'b10, 64'h1111_2222_3333_4444, 0, "R2");
    step(1, 2'b11, 64'h5555_6666_7777_8888, 0, "R2");
    step(1, 2'b11, 64'h5555_6666_7777_8888, 0, "R2");
    step(1, 2'b11, 64'h9999_AAAA_BBBB_CCCC, 1, "R2");
    step(0, 2'b00, 64'd0, 1, "R2");

    for (int k = 0; k < 600; k++) begin
      logic [1:0]  op;
      logic [63:0] d;
      string       t;
      op = 2'($urandom);
      d  = {$urandom, $urandom};
      if (op == 2'b00) begin
        d[62:55] = 8'(120 + $urandom % 32);
        d[30:23] = 8'(120 + $urandom % 32);
      end
      case (op)
        2'b00: t = "R3";
        2'b01: t = "R7";
        2'b10: t = "R8";
        default: t = "R9";
      endcase
      step(1'($urandom % 4 != 0), op, d, 1'($urandom % 3 != 0), t);
    end
    repeat (3) step(0, 2'b00, 64'd0, 1, "R2");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule